// File: doc/BRIEF.md
# Byte-Serial Immediate ALU Executor

This block executes a small family of 32-bit immediate-operand integer instructions that arrive one byte per clock on a valid/ready stream. An opcode byte comes first. Some opcodes are followed by an operand-selector byte, and every opcode is followed by a 32-bit immediate. The block then adds, subtracts, ANDs, ORs, XORs, compares or moves that immediate against a destination. The destination is either one of eight internal 32-bit registers or a word in an external data memory, addressed by the contents of a register.

Register-destination instructions complete on the clock edge that accepts the last immediate byte. Memory-destination instructions run a read, modify and write sequence on a single-word memory port. During that sequence the block reports busy and accepts no bytes. Sign, zero and overflow flags are held in registers. A side read port lets the surrounding logic observe any register. An encoding outside the supported set raises a sticky halt, which only reset clears.

Top module: `imm_alu_exec`

## Requirements
- R1: The four immediate bytes arrive least-significant first; bytes 0a 0b 0c 0d form 0x0d0c0b0a.
- R2: Opcode 0xb8 is followed by a byte whose bits [2:0] name a register, then the immediate, which is written to that register; flags are unchanged.
- R3: Opcode 0x81 takes a selector byte whose bits [5:3] choose the operation: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. With selector bits [7:6] = 11, the destination is the register in bits [2:0], and the result is written there.
- R4: Opcodes 0x2d (subtract), 0x25 (and), 0x0d (or), 0x35 (xor) and 0x3d (compare) take no selector byte and operate on register 0.
- R5: Every arithmetic and logic operation sets SF to result bit 31 and ZF when the result is zero. It sets OF on signed overflow for add, subtract and compare, and clears OF for and, or and xor.
- R6: Compare computes destination minus immediate and updates the flags only; no register or memory word changes.
- R7: With selector bits [7:6] = 00, the destination is the memory word addressed by the register in bits [2:0]. The sequence is a read request, then a cycle with no request, then a write request (no write for compare). The block is busy for 3 cycles (2 for compare), and in_ready is low throughout.
- R8: Opcode 0xc7 stores the immediate to the selected destination without reading it first: to a register, or with a single memory write (busy for 1 cycle).
- R9: An unknown opcode, a 0x81 operation code of 2 or 3, or selector mode 01 or 10 (for 0x81 or 0xc7) sets halted. While halted, in_ready stays low, no memory request is made, and no register or flag changes until reset.
- R10: Synchronous reset clears all registers, flags and halted, and leaves in_ready high.
- R11: After a register-destination instruction, the next byte can be accepted in the very next cycle; busy never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| busy | output | 1 | Memory read-modify-write in progress |
| halted | output | 1 | Sticky error: unsupported encoding seen |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| peek_sel | input | RAW | Register index for the side read port |
| peek_data | output | W | Contents of the selected register (combinational) |

## Verification
The bench builds the block with eight registers and a 6-bit memory address. Every pointer register value therefore selects one of 64 words in a small bench memory, and the store to the top word exercises the address boundary. After each instruction, a behavioural model that works on 64-bit integer arithmetic is compared with all registers, flags, the halt state and every memory word. The number of busy cycles is also checked against the expected read, modify and write sequence. The model's overflow rule compares the truncated result with the exact wide result, so operands at the signed limits separate correct overflow logic from sign-bit shortcuts.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_OR, ALU_AND, ALU_SUB, ALU_XOR, ALU_CMP, ALU_MOV
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_SEL, ST_IMM, ST_MRD, ST_MMOD, ST_MWR, ST_HALT
  } state_e;

  // kind of operand selector expected after the opcode
  typedef enum logic [1:0] {
    K_GRP, K_STORE, K_REGLD, K_ACC
  } kind_e;

  typedef struct packed {
    logic sf;
    logic zf;
    logic of;
  } flags_t;

  localparam logic [7:0] OPC_GRP    = 8'h81;
  localparam logic [7:0] OPC_STORE  = 8'hc7;
  localparam logic [7:0] OPC_REGLD  = 8'hb8;
  localparam logic [7:0] OPC_ACC_SUB = 8'h2d;
  localparam logic [7:0] OPC_ACC_AND = 8'h25;
  localparam logic [7:0] OPC_ACC_OR  = 8'h0d;
  localparam logic [7:0] OPC_ACC_XOR = 8'h35;
  localparam logic [7:0] OPC_ACC_CMP = 8'h3d;

  localparam logic [1:0] MODE_REG = 2'b11;
  localparam logic [1:0] MODE_MEM = 2'b00;

endpackage

// File: rtl/ie_alu.sv
module ie_alu
  import imm_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output flags_t       fl,
  output logic         wr_en
);

  logic a_s, b_s, r_s;

  always_comb begin
    unique case (op)
      ALU_ADD:          res = a + b;
      ALU_SUB, ALU_CMP: res = a - b;
      ALU_AND:          res = a & b;
      ALU_OR:           res = a | b;
      ALU_XOR:          res = a ^ b;
      default:          res = b;
    endcase
  end

  assign a_s = a[W-1];
  assign b_s = b[W-1];
  assign r_s = res[W-1];

  always_comb begin
    fl.sf = r_s;
    fl.zf = (res == '0);
    unique case (op)
      ALU_ADD:          fl.of = (a_s == b_s) && (r_s != a_s);
      ALU_SUB, ALU_CMP: fl.of = (a_s != b_s) && (r_s != a_s);
      default:          fl.of = 1'b0;
    endcase
  end

  assign wr_en = (op != ALU_CMP);

endmodule

// File: rtl/ie_regfile.sv
module ie_regfile #(
  parameter int W    = 32,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd,
  input  logic [RAW-1:0] ra0,
  output logic [W-1:0]   rd0,
  input  logic [RAW-1:0] ra1,
  output logic [W-1:0]   rd1
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && wa == RAW'(g))
        regs[g] <= wd;
    end
  end

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];

endmodule

// File: rtl/ie_ctrl.sv
module ie_ctrl
  import imm_exec_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG),
  localparam int NB  = W / 8,
  localparam int CW  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [7:0]     in_byte,
  output logic           in_ready,
  output logic           busy,
  output logic           halted,
  output alu_op_e        op,
  output logic [RAW-1:0] rsel,
  output logic [W-1:0]   imm_now,
  output logic           reg_exec,
  output logic           mem_start,
  output logic           mem_rd,
  output logic           mem_mod,
  output logic           mem_wr
);

  state_e         st;
  kind_e          kind_q;
  alu_op_e        op_q;
  logic [RAW-1:0] rsel_q;
  logic           mem_q;
  logic [W-1:0]   imm_q;
  logic [CW-1:0]  cnt_q;

  logic take, last;

  // opcode decode
  kind_e   dk;
  alu_op_e dop;
  logic    dbad;

  always_comb begin
    dk   = K_ACC;
    dop  = ALU_MOV;
    dbad = 1'b0;
    unique case (in_byte)
      OPC_GRP:     dk = K_GRP;
      OPC_STORE:   dk = K_STORE;
      OPC_REGLD:   dk = K_REGLD;
      OPC_ACC_SUB: dop = ALU_SUB;
      OPC_ACC_AND: dop = ALU_AND;
      OPC_ACC_OR:  dop = ALU_OR;
      OPC_ACC_XOR: dop = ALU_XOR;
      OPC_ACC_CMP: dop = ALU_CMP;
      default:     dbad = 1'b1;
    endcase
  end

  // operand selector decode
  logic [1:0] s_mode;
  logic [2:0] s_fn;
  alu_op_e    sop;
  logic       smem, sbad;

  assign s_mode = in_byte[7:6];
  assign s_fn   = in_byte[5:3];

  always_comb begin
    sop  = op_q;
    smem = 1'b0;
    sbad = 1'b0;
    if (kind_q != K_REGLD) begin
      if (s_mode == MODE_MEM)      smem = 1'b1;
      else if (s_mode != MODE_REG) sbad = 1'b1;
    end
    if (kind_q == K_GRP) begin
      unique case (s_fn)
        3'd0:    sop = ALU_ADD;
        3'd1:    sop = ALU_OR;
        3'd4:    sop = ALU_AND;
        3'd5:    sop = ALU_SUB;
        3'd6:    sop = ALU_XOR;
        3'd7:    sop = ALU_CMP;
        default: sbad = 1'b1;
      endcase
    end
  end

  assign in_ready = (st == ST_OPC) || (st == ST_SEL) || (st == ST_IMM);
  assign busy     = (st == ST_MRD) || (st == ST_MMOD) || (st == ST_MWR);
  assign halted   = (st == ST_HALT);
  assign take     = in_ready && in_valid;
  assign last     = (st == ST_IMM) && take && (cnt_q == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_OPC;
      kind_q <= K_ACC;
      op_q   <= ALU_MOV;
      rsel_q <= '0;
      mem_q  <= 1'b0;
      imm_q  <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st)
        ST_OPC: if (take) begin
          cnt_q <= '0;
          if (dbad) begin
            st <= ST_HALT;
          end else begin
            kind_q <= dk;
            op_q   <= dop;
            if (dk == K_ACC) begin
              rsel_q <= '0;
              mem_q  <= 1'b0;
              st     <= ST_IMM;
            end else begin
              st <= ST_SEL;
            end
          end
        end
        ST_SEL: if (take) begin
          if (sbad) begin
            st <= ST_HALT;
          end else begin
            op_q   <= sop;
            mem_q  <= smem;
            rsel_q <= RAW'(in_byte[2:0]);
            st     <= ST_IMM;
          end
        end
        ST_IMM: if (take) begin
          imm_q <= {in_byte, imm_q[W-1:8]};
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            if (!mem_q)               st <= ST_OPC;
            else if (op_q == ALU_MOV) st <= ST_MWR;
            else                      st <= ST_MRD;
          end
        end
        ST_MRD:  st <= ST_MMOD;
        ST_MMOD: st <= (op_q == ALU_CMP) ? ST_OPC : ST_MWR;
        ST_MWR:  st <= ST_OPC;
        default: st <= ST_HALT;
      endcase
    end
  end

  assign op        = op_q;
  assign rsel      = rsel_q;
  assign imm_now   = last ? {in_byte, imm_q[W-1:8]} : imm_q;
  assign reg_exec  = last && !mem_q;
  assign mem_start = last && mem_q;
  assign mem_rd    = (st == ST_MRD);
  assign mem_mod   = (st == ST_MMOD);
  assign mem_wr    = (st == ST_MWR);

endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
  import imm_exec_pkg::*;
#(
  parameter int W      = 32,
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  localparam int RAW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              busy,
  output logic              halted,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  output logic              flag_sf,
  output logic              flag_zf,
  output logic              flag_of,
  input  logic [RAW-1:0]    peek_sel,
  output logic [W-1:0]      peek_data
);

  alu_op_e        op;
  logic [RAW-1:0] rsel;
  logic [W-1:0]   imm_now, dst_val, alu_a, alu_res;
  logic           reg_exec, mem_start, mem_rd, mem_mod, mem_wr, alu_wr;
  flags_t         alu_fl, flags_q;
  logic [ADDR_W-1:0] addr_q;
  logic [W-1:0]   wdata_q;

  ie_ctrl #(.W(W), .NREG(NREG)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_ready (in_ready),
    .busy     (busy),
    .halted   (halted),
    .op       (op),
    .rsel     (rsel),
    .imm_now  (imm_now),
    .reg_exec (reg_exec),
    .mem_start(mem_start),
    .mem_rd   (mem_rd),
    .mem_mod  (mem_mod),
    .mem_wr   (mem_wr)
  );

  ie_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (reg_exec && alu_wr),
    .wa  (rsel),
    .wd  (alu_res),
    .ra0 (rsel),
    .rd0 (dst_val),
    .ra1 (peek_sel),
    .rd1 (peek_data)
  );

  assign alu_a = mem_mod ? mem_rdata : dst_val;

  ie_alu #(.W(W)) u_alu (
    .op   (op),
    .a    (alu_a),
    .b    (imm_now),
    .res  (alu_res),
    .fl   (alu_fl),
    .wr_en(alu_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      flags_q <= '0;
    end else begin
      if (mem_start) begin
        addr_q  <= dst_val[ADDR_W-1:0];
        wdata_q <= imm_now;
      end
      if (mem_mod)
        wdata_q <= alu_res;
      if ((reg_exec || mem_mod) && op != ALU_MOV)
        flags_q <= alu_fl;
    end
  end

  assign mem_req   = mem_rd || mem_wr;
  assign mem_we    = mem_wr;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign flag_sf   = flags_q.sf;
  assign flag_zf   = flags_q.zf;
  assign flag_of   = flags_q.of;

endmodule

// File: rtl/imm_alu_exec_chk.sv
module imm_alu_exec_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              busy,
  input logic              halted,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              flag_sf,
  input logic              flag_zf,
  input logic              flag_of
);

  AST_READY_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && busy)); // R7

  AST_READ_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> (busy && !mem_req)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> $stable(mem_addr)); // R7

  AST_FLAGS_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> $stable({flag_sf, flag_zf, flag_of})); // R8

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
    flag_zf |-> !flag_sf); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!in_ready && !busy && !mem_req)); // R9

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !halted && !flag_sf && !flag_zf && !flag_of)); // R10

endmodule

bind imm_alu_exec imm_alu_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_ready(in_ready),
  .busy    (busy),
  .halted  (halted),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .flag_sf (flag_sf),
  .flag_zf (flag_zf),
  .flag_of (flag_of)
);

// File: tb/tb_imm_alu_exec.sv
module tb_imm_alu_exec;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, busy, halted, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic flag_sf, flag_zf, flag_of;
  logic [2:0] peek_sel = '0;
  logic [31:0] peek_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  imm_alu_exec #(.W(32), .NREG(8), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .busy(busy), .halted(halted),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of),
    .peek_sel(peek_sel), .peek_data(peek_data)
  );

  // bench data memory: one-cycle read latency
  logic [31:0] bmem [NW] = '{default: 32'h0};
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  // reference model state
  logic [31:0] m_reg [8];
  logic [31:0] m_mem [NW];
  logic m_sf, m_zf, m_of, m_err;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_sf = 0; m_zf = 0; m_of = 0; m_err = 0;
  endtask

  // op codes: 0 add, 1 or, 4 and, 5 sub, 6 xor, 7 cmp, 8 move
  task automatic model_op(input int op, input logic [31:0] a, input logic [31:0] b, output logic [31:0] r);
    longint sa, sb, w;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      0:       w = sa + sb;
      5, 7:    w = sa - sb;
      1:       w = longint'(a | b);
      4:       w = longint'(a & b);
      6:       w = longint'(a ^ b);
      default: w = longint'(b);
    endcase
    r = w[31:0];
    if (op != 8) begin
      m_sf = r[31];
      m_zf = (r == 32'h0);
      m_of = (op == 0 || op == 5 || op == 7) ? (w != longint'($signed(r))) : 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_imm(input logic [31:0] v);
    for (int i = 0; i < 4; i++) send(v[8*i +: 8]);
  endtask

  task automatic compare_all(input string tag);
    int bad;
    for (int i = 0; i < 8; i++) begin
      peek_sel = 3'(i);
      #1;
      chk(peek_data === m_reg[i], tag, peek_data, m_reg[i]);
    end
    chk({flag_sf, flag_zf, flag_of} === {m_sf, m_zf, m_of}, tag,
        {29'h0, flag_sf, flag_zf, flag_of}, {29'h0, m_sf, m_zf, m_of});
    chk(halted === m_err, tag, {31'h0, halted}, {31'h0, m_err});
    bad = 0;
    for (int i = 0; i < NW; i++) if (bmem[i] !== m_mem[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic finish_instr(input int exp_busy, input string tag);
    int c;
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_busy == 0) chk(in_ready === 1'b1, {tag, " R11 ready"}, {31'h0, in_ready}, 1);
    c = 0;
    while (busy) begin
      c++;
      chk(in_ready === 1'b0, {tag, " R7 ready low"}, {31'h0, in_ready}, 0);
      @(negedge clk);
    end
    chk(c == exp_busy, {tag, " busy cycles"}, c, exp_busy);
    compare_all(tag);
  endtask

  task automatic do_regld(input logic [7:0] sel, input logic [31:0] imm, input string tag);
    send(8'hb8); send(sel); send_imm(imm);
    m_reg[sel[2:0]] = imm;
    finish_instr(0, tag);
  endtask

  task automatic do_grp(input logic [7:0] sel, input logic [31:0] imm, input string tag);
    logic [31:0] a, r;
    int op;
    send(8'h81); send(sel); send_imm(imm);
    op = int'(sel[5:3]);
    if (sel[7:6] == 2'b11) begin
      model_op(op, m_reg[sel[2:0]], imm, r);
      if (op != 7) m_reg[sel[2:0]] = r;
      finish_instr(0, tag);
    end else begin
      a = m_mem[m_reg[sel[2:0]][AW-1:0]];
      model_op(op, a, imm, r);
      if (op != 7) m_mem[m_reg[sel[2:0]][AW-1:0]] = r;
      finish_instr(op == 7 ? 2 : 3, tag);
    end
  endtask

  task automatic do_acc(input logic [7:0] opc, input logic [31:0] imm, input string tag);
    logic [31:0] r;
    int op;
    case (opc)
      8'h2d:   op = 5;
      8'h25:   op = 4;
      8'h0d:   op = 1;
      8'h35:   op = 6;
      default: op = 7;
    endcase
    send(opc); send_imm(imm);
    model_op(op, m_reg[0], imm, r);
    if (op != 7) m_reg[0] = r;
    finish_instr(0, tag);
  endtask

  task automatic do_store(input logic [7:0] sel, input logic [31:0] imm, input string tag);
    send(8'hc7); send(sel); send_imm(imm);
    if (sel[7:6] == 2'b11) begin
      m_reg[sel[2:0]] = imm;
      finish_instr(0, tag);
    end else begin
      m_mem[m_reg[sel[2:0]][AW-1:0]] = imm;
      finish_instr(1, tag);
    end
  endtask

  task automatic do_bad(input logic [7:0] b0, input bit two, input logic [7:0] b1, input string tag);
    send(b0);
    if (two) send(b1);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'hb8;
    m_err = 1'b1;
    chk(halted === 1'b1, {tag, " halted"}, {31'h0, halted}, 1);
    chk(in_ready === 1'b0, {tag, " ready low"}, {31'h0, in_ready}, 0);
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    compare_all({tag, " frozen"});
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(in_ready === 1'b1, {tag, " ready"}, {31'h0, in_ready}, 1);
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    model_reset();
    do_reset("R10 initial reset");

    // immediate assembly and register loads
    do_regld(8'h03, 32'h0d0c0b0a, "R1 R2 load r3");
    do_regld(8'hf9, 32'h7fffffff, "R2 load r1 upper bits ignored");
    do_regld(8'h02, 32'h80000000, "R2 load r2");
    do_regld(8'h00, 32'h0d0c0baa, "R2 load r0");
    do_regld(8'h06, 32'hd0c0b0a0, "R2 load r6");
    do_regld(8'h07, 32'h00000020, "R2 load r7 pointer");

    // group opcode on registers
    do_grp(8'hc3, 32'h00000001, "R3 add r3");
    do_grp(8'hc1, 32'h00000001, "R5 add overflow r1");
    do_grp(8'hea, 32'h00000001, "R5 sub overflow r2");
    do_grp(8'hce, 32'h0d0c0b0a, "R3 or r6");
    do_grp(8'hf6, 32'h0d0c0b0a, "R3 xor r6");
    do_grp(8'he6, 32'h0f0f0f0f, "R3 and r6");
    do_grp(8'hfb, 32'h0d0c0b0b, "R6 cmp equal r3");
    do_grp(8'hfb, 32'h7fffffff, "R6 cmp lesser r3");
    do_grp(8'hfa, 32'hffffffff, "R6 cmp overflow r2");
    do_regld(8'h05, 32'h12345678, "R2 move keeps flags");
    do_grp(8'hfb, 32'h0d0c0b07, "R6 cmp greater r3");

    // accumulator short forms
    do_acc(8'h2d, 32'h0d0c0b0a, "R4 acc sub");
    do_acc(8'h0d, 32'hd0c0b000, "R4 acc or");
    do_acc(8'h35, 32'h0d0c0b0a, "R4 acc xor");
    do_acc(8'h25, 32'h000000ff, "R4 acc and");
    do_acc(8'h3d, 32'h000000a0, "R4 acc cmp");
    do_acc(8'h25, 32'h00000000, "R5 acc and zero");

    // memory destinations through r7
    do_store(8'h07, 32'h000000ff, "R8 store mem");
    do_grp(8'h07, 32'h0d0c0b0a, "R7 mem add");
    do_grp(8'h2f, 32'h00000001, "R7 mem sub");
    do_grp(8'h27, 32'h00ff00ff, "R7 mem and");
    do_grp(8'h0f, 32'hd0c0b0a0, "R7 mem or");
    do_grp(8'h37, 32'hffffffff, "R7 mem xor");
    do_grp(8'h3f, 32'h2f3f4f5f, "R6 R7 mem cmp");
    do_store(8'hc4, 32'hcafe0001, "R8 store reg");
    do_regld(8'h07, 32'hffffffff, "R2 pointer top word");
    do_store(8'h07, 32'h80000000, "R8 store top word");
    do_grp(8'h07, 32'h80000000, "R7 R5 mem add overflow");

    // fatal encodings
    do_bad(8'h81, 1'b1, 8'hd3, "R9 group op 2");
    do_reset("R10 reset after halt");
    do_regld(8'h03, 32'h00000011, "R2 load after reset");
    do_bad(8'h81, 1'b1, 8'h5b, "R9 group op 3");
    do_reset("R10 reset again");
    do_bad(8'h81, 1'b1, 8'h43, "R9 mode 01");
    do_reset("R10 reset mode");
    do_bad(8'hc7, 1'b1, 8'h83, "R9 store mode 10");
    do_reset("R10 reset store");
    do_bad(8'h90, 1'b0, 8'h00, "R9 unknown opcode");
    do_reset("R10 reset opcode");
    do_grp(8'hc0, 32'h00000000, "R5 add zero result");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule